// File: doc/BRIEF.md
# Shared Refill DMA Request Block for Two Display FIFOs

This block sits between a DMA bus master and two display pipelines, a VGA output and an LCD output. Each display drains pixel words from a local FIFO at its own pace, and this block decides when to ask the DMA engine for a refill burst and where the returned words go.

In split mode the two FIFOs are independent. Each one raises its own request and takes words from its own data channel. In joint mode, used when both screens show the same image, one request is raised on the VGA channel and every accepted word is written into both FIFOs. This halves the memory traffic. The joint request waits until both FIFOs have room for a whole burst. If one display drains much faster than the other, its FIFO can run dry while the request is held back by the fuller FIFO. The block reports both fill levels, a skew warning, and sticky underflow flags so that this case can be seen.

A single control write sets both display enables and the requested mode together. A mode change waits until no burst is outstanding.

Top module: `shared_refill_dma`

## Requirements
- R1: After reset, both requests and readies are low, both FIFOs are empty, both underflow flags are clear, both enables are off and the mode is split.
- R2: In split mode, a channel's request rises when no burst is open on that channel, its enable is set, no mode change is pending, and its FIFO has at least BURST free entries. On a DMA channel, ready equals request. Words accepted on a channel go only into that channel's FIFO.
- R3: Once raised, a request stays high until BURST words have been accepted (valid and ready). It is low in the cycle after the last word, so it cannot be raised again in that cycle.
- R4: In joint mode, the LCD request and ready stay low and LCD-channel valid is ignored. The VGA request rises only when both enables are set and both FIFOs have at least BURST free entries.
- R5: In joint mode, each word accepted on the VGA channel is appended to both FIFOs in the same cycle and in the same order.
- R6: A control write (ctl_we high) takes effect for the next cycle. Bit 0 is the VGA enable, bit 1 is the LCD enable and bit 2 is the requested mode (1 = joint), so one write can start both displays.
- R7: The active mode takes the requested value only in a cycle where neither channel has a burst open. While the two differ, no new burst starts.
- R8: On each display port, valid is high while its FIFO holds data. A word is removed when valid and ready are both high. Words leave in arrival order.
- R9: Display ready while the FIFO is empty sets that display's sticky underflow flag. Writing 1 to control bit 3 clears the VGA flag and writing 1 to bit 4 clears the LCD flag. A new underflow in the same cycle as a clear wins.
- R10: vga_level and lcd_level report FIFO occupancy. skew_warn is high in joint mode when the two levels differ by more than SKEW_LIM.
- R11: Neither FIFO ever holds more than DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data (enables, mode, underflow clears) |
| dma_v_req | output | 1 | VGA-channel burst request (also the joint request) |
| dma_v_valid | input | 1 | VGA-channel data valid |
| dma_v_ready | output | 1 | VGA-channel ready |
| dma_v_data | input | DW | VGA-channel data word |
| dma_l_req | output | 1 | LCD-channel burst request |
| dma_l_valid | input | 1 | LCD-channel data valid |
| dma_l_ready | output | 1 | LCD-channel ready |
| dma_l_data | input | DW | LCD-channel data word |
| vga_valid | output | 1 | VGA FIFO has a word |
| vga_ready | input | 1 | VGA display takes a word |
| vga_data | output | DW | VGA FIFO head word |
| lcd_valid | output | 1 | LCD FIFO has a word |
| lcd_ready | input | 1 | LCD display takes a word |
| lcd_data | output | DW | LCD FIFO head word |
| vga_level | output | LVL_W | VGA FIFO occupancy |
| lcd_level | output | LVL_W | LCD FIFO occupancy |
| vga_uf | output | 1 | Sticky VGA underflow flag |
| lcd_uf | output | 1 | Sticky LCD underflow flag |
| skew_warn | output | 1 | Joint-mode level difference above SKEW_LIM |
| vga_en | output | 1 | VGA enable bit |
| lcd_en | output | 1 | LCD enable bit |
| mode_shared | output | 1 | Active mode, 1 = joint |

## Verification
The hardest state to reach is a joint-mode underflow. The LCD FIFO must run dry while the VGA FIFO is too full to allow the single request. At the same time, a mode change must already have been deferred behind an open burst. The stimulus gets there in steps. It first runs both displays in split mode with random DMA and display back-pressure. It then requests joint mode while bursts are in flight, so the switch has to wait. Finally it sets the LCD display ready almost every cycle and the VGA display ready rarely. The VGA FIFO then fills, the shared request stalls, and the LCD FIFO empties with the skew warning raised.

// File: rtl/refill_pkg.sv
package refill_pkg;
  localparam int CTL_W  = 5;
  localparam int B_VEN  = 0;
  localparam int B_LEN  = 1;
  localparam int B_MODE = 2;
  localparam int B_CLRV = 3;
  localparam int B_CLRL = 4;

  localparam int CH_VGA = 0;
  localparam int CH_LCD = 1;
  localparam int N_CH   = 2;

  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_JOINT = 1'b1
  } mode_e;
endpackage

// File: rtl/refill_fifo.sv
module refill_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  output logic [LVL_W-1:0] level,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [LVL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + LVL_W'(push) - LVL_W'(pop);
    end
  end

  assign dout  = mem[rp];
  assign level = cnt;
  assign empty = (cnt == '0);
endmodule

// File: rtl/refill_burst.sv
module refill_burst #(
  parameter int BURST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic beat,
  output logic busy
);
  localparam int CW = (BURST > 1) ? $clog2(BURST) : 1;

  logic [CW-1:0] cnt;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt    <= '0;
      end
    end else if (beat) begin
      if (cnt == CW'(BURST - 1)) busy_q <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/refill_ctl.sv
module refill_ctl
  import refill_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             idle,
  input  logic             v_uf_evt,
  input  logic             l_uf_evt,
  output logic             ven,
  output logic             len,
  output mode_e            mode,
  output logic             change_pend,
  output logic             v_uf,
  output logic             l_uf
);
  mode_e pend_q, mode_q;
  logic  ven_q, len_q, vuf_q, luf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ven_q  <= 1'b0;
      len_q  <= 1'b0;
      pend_q <= MODE_SPLIT;
      mode_q <= MODE_SPLIT;
      vuf_q  <= 1'b0;
      luf_q  <= 1'b0;
    end else begin
      if (we) begin
        ven_q  <= wdata[B_VEN];
        len_q  <= wdata[B_LEN];
        pend_q <= mode_e'(wdata[B_MODE]);
      end
      if (idle) mode_q <= pend_q;
      vuf_q <= (vuf_q & ~(we & wdata[B_CLRV])) | v_uf_evt;
      luf_q <= (luf_q & ~(we & wdata[B_CLRL])) | l_uf_evt;
    end
  end

  assign ven         = ven_q;
  assign len         = len_q;
  assign mode        = mode_q;
  assign change_pend = (pend_q != mode_q);
  assign v_uf        = vuf_q;
  assign l_uf        = luf_q;
endmodule

// File: rtl/shared_refill_dma.sv
module shared_refill_dma
  import refill_pkg::*;
#(
  parameter int DW       = 32,
  parameter int DEPTH    = 32,
  parameter int BURST    = 8,
  parameter int SKEW_LIM = 8,
  parameter int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [4:0]       ctl_wdata,
  output logic             dma_v_req,
  input  logic             dma_v_valid,
  output logic             dma_v_ready,
  input  logic [DW-1:0]    dma_v_data,
  output logic             dma_l_req,
  input  logic             dma_l_valid,
  output logic             dma_l_ready,
  input  logic [DW-1:0]    dma_l_data,
  output logic             vga_valid,
  input  logic             vga_ready,
  output logic [DW-1:0]    vga_data,
  output logic             lcd_valid,
  input  logic             lcd_ready,
  output logic [DW-1:0]    lcd_data,
  output logic [LVL_W-1:0] vga_level,
  output logic [LVL_W-1:0] lcd_level,
  output logic             vga_uf,
  output logic             lcd_uf,
  output logic             skew_warn,
  output logic             vga_en,
  output logic             lcd_en,
  output logic             mode_shared
);
  localparam logic [LVL_W-1:0] CAP  = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] NEED = LVL_W'(BURST);
  localparam logic [LVL_W-1:0] LIM  = LVL_W'(SKEW_LIM);

  logic [N_CH-1:0]  push, pop, empty, busy, start, beat, room, rdy;
  logic [DW-1:0]    din  [N_CH];
  logic [DW-1:0]    dout [N_CH];
  logic [LVL_W-1:0] lvl  [N_CH];
  logic [N_CH-1:0]  dvalid;
  logic [DW-1:0]    ddata [N_CH];

  mode_e mode;
  logic  joint, chg, ven, len, idle;
  logic  v_uf_evt, l_uf_evt;
  logic [LVL_W-1:0] diff;

  assign dvalid[CH_VGA] = dma_v_valid;
  assign dvalid[CH_LCD] = dma_l_valid;
  assign ddata[CH_VGA]  = dma_v_data;
  assign ddata[CH_LCD]  = dma_l_data;
  assign rdy[CH_VGA]    = vga_ready;
  assign rdy[CH_LCD]    = lcd_ready;

  assign joint = (mode == MODE_JOINT);
  assign idle  = ~|busy;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign room[i] = (CAP - lvl[i]) >= NEED;
    assign beat[i] = dvalid[i] & busy[i];
    assign pop[i]  = rdy[i] & ~empty[i];

    refill_fifo #(.DW(DW), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push[i]),
      .din   (din[i]),
      .pop   (pop[i]),
      .dout  (dout[i]),
      .level (lvl[i]),
      .empty (empty[i])
    );

    refill_burst #(.BURST(BURST)) u_burst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start[i]),
      .beat  (beat[i]),
      .busy  (busy[i])
    );
  end

  // Request generation: joint mode drives only the VGA channel
  always_comb begin
    start[CH_VGA] = ~chg & ven & room[CH_VGA] &
                    (joint ? (len & room[CH_LCD]) : 1'b1);
    start[CH_LCD] = ~chg & ~joint & len & room[CH_LCD];
  end

  // Write routing: joint mode fans the VGA beat into both FIFOs
  always_comb begin
    push[CH_VGA] = beat[CH_VGA];
    din[CH_VGA]  = ddata[CH_VGA];
    push[CH_LCD] = joint ? beat[CH_VGA] : beat[CH_LCD];
    din[CH_LCD]  = joint ? ddata[CH_VGA] : ddata[CH_LCD];
  end

  assign v_uf_evt = vga_ready & empty[CH_VGA];
  assign l_uf_evt = lcd_ready & empty[CH_LCD];

  refill_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (ctl_we),
    .wdata       (ctl_wdata),
    .idle        (idle),
    .v_uf_evt    (v_uf_evt),
    .l_uf_evt    (l_uf_evt),
    .ven         (ven),
    .len         (len),
    .mode        (mode),
    .change_pend (chg),
    .v_uf        (vga_uf),
    .l_uf        (lcd_uf)
  );

  assign diff = (lvl[CH_VGA] > lvl[CH_LCD]) ? (lvl[CH_VGA] - lvl[CH_LCD])
                                            : (lvl[CH_LCD] - lvl[CH_VGA]);

  assign dma_v_req   = busy[CH_VGA];
  assign dma_v_ready = busy[CH_VGA];
  assign dma_l_req   = busy[CH_LCD];
  assign dma_l_ready = busy[CH_LCD];
  assign vga_valid   = ~empty[CH_VGA];
  assign lcd_valid   = ~empty[CH_LCD];
  assign vga_data    = dout[CH_VGA];
  assign lcd_data    = dout[CH_LCD];
  assign vga_level   = lvl[CH_VGA];
  assign lcd_level   = lvl[CH_LCD];
  assign skew_warn   = joint & (diff > LIM);
  assign vga_en      = ven;
  assign lcd_en      = len;
  assign mode_shared = joint;
endmodule

// File: rtl/shared_refill_dma_chk.sv
module shared_refill_dma_chk #(
  parameter int DEPTH = 32,
  parameter int BURST = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_v_req,
  input logic             dma_v_valid,
  input logic             dma_l_req,
  input logic             vga_valid,
  input logic             vga_ready,
  input logic             lcd_valid,
  input logic             lcd_ready,
  input logic [LVL_W-1:0] vga_level,
  input logic [LVL_W-1:0] lcd_level,
  input logic             vga_uf,
  input logic             lcd_uf,
  input logic             vga_en,
  input logic             lcd_en,
  input logic             mode_shared
);
  assert_vreq_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_v_req) |-> $past(vga_en));

  assert_lreq_needs_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_l_req) |-> ($past(lcd_en) && !$past(mode_shared)));

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_v_req && !dma_v_valid) |=> dma_v_req);

  assert_lcd_quiet_joint_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_shared |-> !dma_l_req);

  assert_joint_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dma_v_req) && mode_shared) |->
      ($past(lcd_en) && ($past(lcd_level) <= LVL_W'(DEPTH - BURST))));

  assert_mode_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_shared) |-> (!$past(dma_v_req) && !$past(dma_l_req)));

  assert_vga_uf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vga_ready && !vga_valid) |=> vga_uf);

  assert_lcd_uf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_ready && !lcd_valid) |=> lcd_uf);

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vga_level <= LVL_W'(DEPTH)) && (lcd_level <= LVL_W'(DEPTH)));
endmodule

bind shared_refill_dma shared_refill_dma_chk #(
  .DEPTH (DEPTH),
  .BURST (BURST),
  .LVL_W (LVL_W)
) u_chk (.*);

// File: tb/shared_refill_dma_bench.sv
`timescale 1ns/1ps
module shared_refill_dma_bench;
  localparam int DW       = 32;
  localparam int DEPTH    = 32;
  localparam int BURST    = 8;
  localparam int SKEW_LIM = 8;
  localparam int LVL_W    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             ctl_we = 1'b0;
  logic [4:0]       ctl_wdata = '0;
  logic             dma_v_req, dma_v_ready, dma_l_req, dma_l_ready;
  logic             dma_v_valid = 1'b0, dma_l_valid = 1'b0;
  logic [DW-1:0]    dma_v_data = '0, dma_l_data = '0;
  logic             vga_valid, lcd_valid;
  logic             vga_ready = 1'b0, lcd_ready = 1'b0;
  logic [DW-1:0]    vga_data, lcd_data;
  logic [LVL_W-1:0] vga_level, lcd_level;
  logic             vga_uf, lcd_uf, skew_warn, vga_en, lcd_en, mode_shared;

  shared_refill_dma #(.DW(DW), .DEPTH(DEPTH), .BURST(BURST),
                      .SKEW_LIM(SKEW_LIM)) u_shared_refill_dma (.*);

  int nchk = 0, nfail = 0;
  int pv = 0, pl = 0, rv = 0, rl = 0;
  bit run = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] qv[$], ql[$];
  bit m_vbusy, m_lbusy, m_share, m_pend, m_ven, m_len, m_vuf, m_luf;
  int m_vcnt, m_lcnt;

  always @(posedge clk) begin : model
    int vs, ls;
    bit chg, vok, lok, vbeat, lbeat, vpop, lpop, vufe, lufe, idle;
    if (!rst_n) begin
      qv.delete(); ql.delete();
      m_vbusy = 0; m_lbusy = 0; m_share = 0; m_pend = 0;
      m_ven = 0; m_len = 0; m_vuf = 0; m_luf = 0; m_vcnt = 0; m_lcnt = 0;
    end else begin
      vs = qv.size(); ls = ql.size();
      chg = (m_pend != m_share);
      vok = !chg && m_ven && (DEPTH - vs >= BURST) &&
            (!m_share || (m_len && (DEPTH - ls >= BURST)));
      lok = !chg && !m_share && m_len && (DEPTH - ls >= BURST);
      vbeat = dma_v_valid && m_vbusy;
      lbeat = dma_l_valid && m_lbusy;
      vpop = vga_ready && vs > 0;
      lpop = lcd_ready && ls > 0;
      vufe = vga_ready && vs == 0;
      lufe = lcd_ready && ls == 0;
      idle = !m_vbusy && !m_lbusy;
      if (vpop) void'(qv.pop_front());
      if (lpop) void'(ql.pop_front());
      if (vbeat) qv.push_back(dma_v_data);
      if (m_share ? vbeat : lbeat) ql.push_back(m_share ? dma_v_data : dma_l_data);
      if (!m_vbusy) begin
        if (vok) begin m_vbusy = 1; m_vcnt = 0; end
      end else if (vbeat) begin
        if (m_vcnt == BURST - 1) m_vbusy = 0;
        m_vcnt++;
      end
      if (!m_lbusy) begin
        if (lok) begin m_lbusy = 1; m_lcnt = 0; end
      end else if (lbeat) begin
        if (m_lcnt == BURST - 1) m_lbusy = 0;
        m_lcnt++;
      end
      m_vuf = (m_vuf && !(ctl_we && ctl_wdata[3])) || vufe;
      m_luf = (m_luf && !(ctl_we && ctl_wdata[4])) || lufe;
      if (idle) m_share = m_pend;
      if (ctl_we) begin
        m_ven = ctl_wdata[0]; m_len = ctl_wdata[1]; m_pend = ctl_wdata[2];
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    int d;
    if (run) begin
      chk("R2 R3 vga req", dma_v_req, m_vbusy);
      chk("R2 vga ready", dma_v_ready, m_vbusy);
      chk(m_share ? "R4 lcd req" : "R2 R3 lcd req", dma_l_req, m_lbusy);
      chk("R2 lcd ready", dma_l_ready, m_lbusy);
      chk("R8 vga valid", vga_valid, qv.size() > 0);
      chk("R8 lcd valid", lcd_valid, ql.size() > 0);
      if (qv.size() > 0) chk("R8 vga data", vga_data, qv[0]);
      if (ql.size() > 0) chk(m_share ? "R5 lcd data" : "R8 lcd data", lcd_data, ql[0]);
      chk("R10 vga level", vga_level, qv.size());
      chk(m_share ? "R5 lcd level" : "R10 lcd level", lcd_level, ql.size());
      chk("R9 vga uf", vga_uf, m_vuf);
      chk("R9 lcd uf", lcd_uf, m_luf);
      chk("R6 enables", {vga_en, lcd_en}, {m_ven, m_len});
      chk("R7 mode", mode_shared, m_share);
      d = qv.size() - ql.size();
      if (d < 0) d = -d;
      chk("R10 skew", skew_warn, m_share && d > SKEW_LIM);
      chk("R11 bound", (vga_level <= DEPTH) && (lcd_level <= DEPTH), 1);
    end
  end

  // random stimulus, driven at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      dma_v_valid = ($urandom % 100) < pv;
      dma_l_valid = ($urandom % 100) < pl;
      dma_v_data  = $urandom;
      dma_l_data  = $urandom;
      vga_ready   = ($urandom % 100) < rv;
      lcd_ready   = ($urandom % 100) < rl;
    end
  end

  task automatic wr(input logic [4:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 reqs", {dma_v_req, dma_l_req, dma_v_ready, dma_l_ready}, 0);
    chk("R1 levels", {vga_level, lcd_level}, 0);
    chk("R1 flags", {vga_uf, lcd_uf, vga_valid, lcd_valid}, 0);
    chk("R1 ctl", {vga_en, lcd_en, mode_shared, skew_warn}, 0);
    run = 1;
    // split mode, both enabled by one write (R6, R2, R3, R8)
    pv = 70; pl = 50; rv = 40; rl = 60;
    wr(5'b00011);
    repeat (1500) @(negedge clk);
    // underflows and write-1 clears (R9)
    pv = 5; pl = 5; rv = 90; rl = 90;
    repeat (200) @(negedge clk);
    wr(5'b01011);
    repeat (20) @(negedge clk);
    rv = 0; rl = 0;
    repeat (5) @(negedge clk);
    wr(5'b11011);
    repeat (20) @(negedge clk);
    // joint mode requested while traffic runs (R7, R4, R5)
    pv = 80; pl = 60; rv = 30; rl = 30;
    repeat (3) @(negedge clk);
    wr(5'b00111);
    repeat (2000) @(negedge clk);
    // LCD drains fast, VGA slow: skew and LCD underflow (R10, R9)
    rv = 10; rl = 90;
    repeat (600) @(negedge clk);
    wr(5'b10111);
    rv = 50; rl = 50;
    repeat (300) @(negedge clk);
    // back to split mode, then everything off
    wr(5'b00011);
    repeat (500) @(negedge clk);
    wr(5'b00000);
    rv = 100; rl = 100;
    repeat (200) @(negedge clk);
    run = 0;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule